// File: doc/BRIEF.md
# Segment Access Window Checker

This block takes a descriptor that has already been fetched, together with an offset and an access direction, and works out two things: the linear address of the access and how many bytes, from 0 to 255, may be touched starting at that address without leaving the segment. A result of zero means that no byte may be touched. Callers compare the window against their operand size. A window of zero also results when the segment is execute-only, or when a write targets a segment that is not writable.

A mode select chooses the address form. In flat mode the offset is used unchanged. In virtual-8086 mode the address is the 16-bit selector times sixteen plus the offset. In protected mode the descriptor's base, limit, granularity and direction decide the window. In flat mode, a write through a code-segment override raises a fault flag. Each request is given by a one-cycle start pulse. The registered result appears on the next clock edge, together with a one-cycle done strobe.

Top module: `seg_win_checker`

## Requirements
- R1: In protected mode (mode bit 1 set, i.e. mode 2 or 3) the linear address is base plus offset, taken modulo 2^32.
- R2: The effective limit is base + (raw limit + 1) x G - 1. G is 4096 when the granularity input is 1 and 1 when it is 0. If this sum exceeds 32 bits, the limit becomes 0xFFFFFFFF.
- R3: For an expand-up segment the window is 0 when the address is above the effective limit or below the base. Otherwise it is limit - address + 1, saturated to 255 once limit - address reaches 254.
- R4: For an expand-down segment the top is 0xFFFFFFFF when granularity is 1. Otherwise the top is base + 2^20, clamped to 0xFFFFFFFF on carry. The window is 0 when the address is at or below the limit, or at or above the top. Otherwise it is top - address, saturated at 255.
- R5: In protected mode the window is 0 when the segment is execute-only, and also when the access is a write to a segment whose writable input is 0.
- R6: In virtual-8086 mode (mode 1) the address is {selector, 4'b0000} + offset, the window is 255 and the fault flag is 0.
- R7: In flat mode (mode 0) the address equals the offset and the window is 255. Fault is 1 exactly when the access is a write and the code-segment override input is 1.
- R8: The results load on the clock edge that samples start high. Done is high for exactly the cycle after each start. Without a start, all result outputs hold their values.
- R9: Fault is 0 for every request made in virtual-8086 or protected mode. Reset clears done, fault, address and window to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request strobe; inputs sampled on this edge |
| mode | input | 2 | 0 flat, 1 virtual-8086, 2 or 3 protected |
| selector | input | 16 | Segment selector value (used in virtual-8086 mode) |
| seg_base | input | 32 | Descriptor base address |
| seg_limit | input | 20 | Raw descriptor limit |
| gran | input | 1 | Granularity: 1 = 4 KiB units |
| expand_down | input | 1 | Segment grows downward |
| exec_only | input | 1 | Segment is execute-only |
| writable | input | 1 | Segment allows writes |
| offset | input | 32 | Effective offset of the access |
| is_write | input | 1 | Access is a store |
| cs_override | input | 1 | Access goes through the code-segment override |
| done | output | 1 | One-cycle result strobe |
| lin_addr | output | 32 | Linear address |
| window | output | 8 | Bytes accessible from lin_addr, 0 to 255 |
| fault | output | 1 | Write-through-code-segment fault (flat mode) |

## Verification
The assertions assume that every input is stable and known at each clock edge while start is high. They also assume that start is a single-cycle pulse, so that each $past sample belongs to exactly one request. The directed tasks hold every input constant across the edge that samples start and drop start on the following negative edge. The descriptor values are picked to land exactly on the limit, on the top, on the saturation thresholds and on 32-bit carry. They stay within legal 20-bit limits, so no case relies on undefined inputs.

// File: rtl/seg_win_pkg.sv
package seg_win_pkg;
   typedef enum logic [1:0] {
      AM_FLAT  = 2'd0,
      AM_V86   = 2'd1,
      AM_PROT  = 2'd2,
      AM_PROT2 = 2'd3
   } addr_mode_e;

   typedef struct packed {
      logic [31:0] addr;
      logic [7:0]  win;
      logic        fault;
   } seg_result_t;
endpackage

// File: rtl/seg_bound_calc.sv
module seg_bound_calc #(
   parameter int AW        = 32,
   parameter int LW        = 20,
   parameter int PG_SHIFT  = 12,
   parameter int TOP_SHIFT = 20,
   parameter bit GRAN_EN   = 1'b1
) (
   input  logic [AW-1:0] base,
   input  logic [LW-1:0] raw_lim,
   input  logic          gran,
   output logic [AW-1:0] eff_lim,
   output logic [AW-1:0] top
);
   localparam int CW = AW + 1;

   logic [CW-1:0] units;
   logic [CW-1:0] span;
   logic [CW-1:0] lim_sum;
   logic [CW-1:0] top_sum;
   logic          gran_q;

   generate
      if (GRAN_EN) begin : g_gran
         assign gran_q = gran;
      end else begin : g_byte
         assign gran_q = 1'b0;
      end
   endgenerate

   always_comb begin
      units   = {{(CW-LW){1'b0}}, raw_lim} + CW'(1);
      span    = gran_q ? (units << PG_SHIFT) : units;
      lim_sum = {1'b0, base} + span - CW'(1);
      eff_lim = lim_sum[AW] ? {AW{1'b1}} : lim_sum[AW-1:0];
      top_sum = {1'b0, base} + (CW'(1) << TOP_SHIFT);
      if (gran_q)
         top = {AW{1'b1}};
      else
         top = top_sum[AW] ? {AW{1'b1}} : top_sum[AW-1:0];
   end
endmodule

// File: rtl/seg_window_calc.sv
module seg_window_calc #(
   parameter int AW   = 32,
   parameter int WINW = 8
) (
   input  logic [AW-1:0]   addr,
   input  logic [AW-1:0]   base,
   input  logic [AW-1:0]   eff_lim,
   input  logic [AW-1:0]   top,
   input  logic            expand_down,
   input  logic            exec_only,
   input  logic            writable,
   input  logic            is_write,
   output logic [WINW-1:0] win
);
   localparam logic [AW-1:0] SAT    = AW'((1 << WINW) - 1);
   localparam logic [AW-1:0] SAT_M1 = SAT - AW'(1);

   logic [AW-1:0]   up_gap;
   logic [AW-1:0]   dn_gap;
   logic [WINW-1:0] up_win;
   logic [WINW-1:0] dn_win;
   logic            blocked;

   always_comb begin
      up_gap = eff_lim - addr;
      dn_gap = top - addr;

      if (addr > eff_lim || addr < base)
         up_win = '0;
      else if (up_gap >= SAT_M1)
         up_win = SAT[WINW-1:0];
      else
         up_win = up_gap[WINW-1:0] + WINW'(1);

      if (addr <= eff_lim || addr >= top)
         dn_win = '0;
      else if (dn_gap >= SAT)
         dn_win = SAT[WINW-1:0];
      else
         dn_win = dn_gap[WINW-1:0];

      blocked = exec_only || (is_write && !writable);
      win     = blocked ? '0 : (expand_down ? dn_win : up_win);
   end
endmodule

// File: rtl/seg_win_checker.sv
module seg_win_checker
   import seg_win_pkg::*;
#(
   parameter int AW        = 32,
   parameter int LW        = 20,
   parameter int SW        = 16,
   parameter int WINW      = 8,
   parameter int PG_SHIFT  = 12,
   parameter int TOP_SHIFT = 20,
   parameter int SEL_SHIFT = 4,
   parameter bit GRAN_EN   = 1'b1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            start,
   input  logic [1:0]      mode,
   input  logic [SW-1:0]   selector,
   input  logic [AW-1:0]   seg_base,
   input  logic [LW-1:0]   seg_limit,
   input  logic            gran,
   input  logic            expand_down,
   input  logic            exec_only,
   input  logic            writable,
   input  logic [AW-1:0]   offset,
   input  logic            is_write,
   input  logic            cs_override,
   output logic            done,
   output logic [AW-1:0]   lin_addr,
   output logic [WINW-1:0] window,
   output logic            fault
);
   localparam logic [WINW-1:0] WIN_FULL = {WINW{1'b1}};

   generate
      if (LW + PG_SHIFT > AW) begin : g_bad_gran
         $error("seg_win_checker: scaled limit exceeds address width");
      end
      if (SW + SEL_SHIFT > AW) begin : g_bad_sel
         $error("seg_win_checker: shifted selector exceeds address width");
      end
      if (WINW < 2 || WINW >= AW) begin : g_bad_win
         $error("seg_win_checker: window width out of range");
      end
   endgenerate

   logic [AW-1:0]   eff_lim;
   logic [AW-1:0]   top;
   logic [AW-1:0]   prot_addr;
   logic [AW-1:0]   v86_addr;
   logic [WINW-1:0] prot_win;
   logic [AW-1:0]   nxt_addr;
   logic [WINW-1:0] nxt_win;
   logic            nxt_fault;
   addr_mode_e      mode_e;

   assign mode_e    = addr_mode_e'(mode);
   assign prot_addr = seg_base + offset;
   assign v86_addr  = (AW'(selector) << SEL_SHIFT) + offset;

   seg_bound_calc #(
      .AW(AW), .LW(LW), .PG_SHIFT(PG_SHIFT),
      .TOP_SHIFT(TOP_SHIFT), .GRAN_EN(GRAN_EN)
   ) u_bounds (
      .base    (seg_base),
      .raw_lim (seg_limit),
      .gran    (gran),
      .eff_lim (eff_lim),
      .top     (top)
   );

   seg_window_calc #(.AW(AW), .WINW(WINW)) u_window (
      .addr        (prot_addr),
      .base        (seg_base),
      .eff_lim     (eff_lim),
      .top         (top),
      .expand_down (expand_down),
      .exec_only   (exec_only),
      .writable    (writable),
      .is_write    (is_write),
      .win         (prot_win)
   );

   always_comb begin
      nxt_addr  = offset;
      nxt_win   = WIN_FULL;
      nxt_fault = 1'b0;
      unique case (mode_e)
         AM_FLAT: nxt_fault = is_write && cs_override;
         AM_V86:  nxt_addr  = v86_addr;
         AM_PROT, AM_PROT2: begin
            nxt_addr = prot_addr;
            nxt_win  = prot_win;
         end
         default: ;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         done     <= 1'b0;
         lin_addr <= '0;
         window   <= '0;
         fault    <= 1'b0;
      end else begin
         done <= start;
         if (start) begin
            lin_addr <= nxt_addr;
            window   <= nxt_win;
            fault    <= nxt_fault;
         end
      end
   end
endmodule

// File: rtl/seg_win_checker_sva.sv
module seg_win_checker_sva #(
   parameter int AW        = 32,
   parameter int SW        = 16,
   parameter int WINW      = 8,
   parameter int SEL_SHIFT = 4
) (
   input logic            clk,
   input logic            rst_n,
   input logic            start,
   input logic [1:0]      mode,
   input logic [SW-1:0]   selector,
   input logic [AW-1:0]   offset,
   input logic            exec_only,
   input logic            done,
   input logic [AW-1:0]   lin_addr,
   input logic [WINW-1:0] window,
   input logic            fault
);
   a_r8_done_after_start: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> done);
   a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
      !start |=> !done);
   a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !start |=> ($stable(lin_addr) && $stable(window) && $stable(fault)));
   a_r9_no_fault_segmented: assert property (@(posedge clk) disable iff (!rst_n)
      (start && mode != 2'd0) |=> !fault);
   a_r5_exec_only_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (start && mode[1] && exec_only) |=> (window == '0));
   a_r6_v86_form: assert property (@(posedge clk) disable iff (!rst_n)
      (start && mode == 2'd1) |=>
         (window == {WINW{1'b1}} &&
          lin_addr == (AW'($past(selector)) << SEL_SHIFT) + $past(offset)));
   a_r7_flat_addr: assert property (@(posedge clk) disable iff (!rst_n)
      (start && mode == 2'd0) |=> (lin_addr == $past(offset)));
endmodule

bind seg_win_checker seg_win_checker_sva #(
   .AW(AW), .SW(SW), .WINW(WINW), .SEL_SHIFT(SEL_SHIFT)
) u_sva (
   .clk       (clk),
   .rst_n     (rst_n),
   .start     (start),
   .mode      (mode),
   .selector  (selector),
   .offset    (offset),
   .exec_only (exec_only),
   .done      (done),
   .lin_addr  (lin_addr),
   .window    (window),
   .fault     (fault)
);

// File: tb/tb_seg_win_checker.sv
module tb_seg_win_checker;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [1:0]  mode = '0;
   logic [15:0] selector = '0;
   logic [31:0] seg_base = '0;
   logic [19:0] seg_limit = '0;
   logic        gran = 1'b0;
   logic        expand_down = 1'b0;
   logic        exec_only = 1'b0;
   logic        writable = 1'b1;
   logic [31:0] offset = '0;
   logic        is_write = 1'b0;
   logic        cs_override = 1'b0;
   logic        done;
   logic [31:0] lin_addr;
   logic [7:0]  window;
   logic        fault;

   int checks = 0;
   int fails  = 0;

   always #4 clk = ~clk;

   seg_win_checker dut (
      .clk(clk), .rst_n(rst_n), .start(start), .mode(mode),
      .selector(selector), .seg_base(seg_base), .seg_limit(seg_limit),
      .gran(gran), .expand_down(expand_down), .exec_only(exec_only),
      .writable(writable), .offset(offset), .is_write(is_write),
      .cs_override(cs_override), .done(done), .lin_addr(lin_addr),
      .window(window), .fault(fault)
   );

   task automatic check(input string req, input string what,
                        input longint act, input longint exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
      end
   endtask

   // Protected request: drive, let one edge sample start, check on next negedge.
   task automatic prot_req(input string req, input logic [31:0] b,
                           input logic [19:0] l, input logic g, input logic ed,
                           input logic xo, input logic wr, input logic [31:0] off,
                           input logic st, input logic [31:0] exp_addr,
                           input int exp_win);
      @(negedge clk);
      mode = 2'd2; seg_base = b; seg_limit = l; gran = g; expand_down = ed;
      exec_only = xo; writable = wr; offset = off; is_write = st;
      cs_override = 1'b0; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      check(req, "done", done, 1);
      check(req, "addr", lin_addr, exp_addr);
      check(req, "window", window, exp_win);
      check("R9", "fault", fault, 0);
   endtask

   task automatic t_reset();
      check("R9", "reset done", done, 0);
      check("R9", "reset addr", lin_addr, 0);
      check("R9", "reset window", window, 0);
      check("R9", "reset fault", fault, 0);
   endtask

   task automatic t_expand_up();
      // limit = 0x1000 + 0x100 - 1 = 0x10FF
      prot_req("R3", 32'h1000, 20'hFF, 0, 0, 0, 1, 32'h10, 0, 32'h1010, 240);
      prot_req("R3", 32'h1000, 20'hFF, 0, 0, 0, 1, 32'h0,  0, 32'h1000, 255);
      prot_req("R3", 32'h1000, 20'hFF, 0, 0, 0, 1, 32'h1,  0, 32'h1001, 255);
      prot_req("R3", 32'h1000, 20'hFF, 0, 0, 0, 1, 32'h2,  0, 32'h1002, 254);
      prot_req("R3", 32'h1000, 20'hFF, 0, 0, 0, 1, 32'hFF, 0, 32'h10FF, 1);
      prot_req("R3", 32'h1000, 20'hFF, 0, 0, 0, 1, 32'h100, 0, 32'h1100, 0);
      // address wraps below base (R1 modulo 2^32)
      prot_req("R1", 32'h1000, 20'hFF, 0, 0, 0, 1, 32'hFFFFFF00, 0, 32'h0F00, 0);
   endtask

   task automatic t_gran_wrap();
      // gran: limit = 0x2000 + 2*4096 - 1 = 0x3FFF
      prot_req("R2", 32'h2000, 20'h1, 1, 0, 0, 1, 32'h1FF0, 0, 32'h3FF0, 16);
      prot_req("R2", 32'h2000, 20'h1, 1, 0, 0, 1, 32'h2000, 0, 32'h4000, 0);
      // limit sum carries past 32 bits: clamped to 0xFFFFFFFF
      prot_req("R2", 32'hFFFFF000, 20'hFFFFF, 1, 0, 0, 1, 32'hFF0, 0, 32'hFFFFFFF0, 16);
   endtask

   task automatic t_expand_down();
      // limit 0x10FFF, top 0x110000
      prot_req("R4", 32'h10000, 20'hFFF, 0, 1, 0, 1, 32'hFFF,    0, 32'h10FFF,  0);
      prot_req("R4", 32'h10000, 20'hFFF, 0, 1, 0, 1, 32'h1000,   0, 32'h11000,  255);
      prot_req("R4", 32'h10000, 20'hFFF, 0, 1, 0, 1, 32'hFFFF8,  0, 32'h10FFF8, 8);
      prot_req("R4", 32'h10000, 20'hFFF, 0, 1, 0, 1, 32'h100000, 0, 32'h110000, 0);
      // top = base + 2^20 carries: clamped
      prot_req("R4", 32'hFFF80000, 20'h0, 0, 1, 0, 1, 32'h7FFF0, 0, 32'hFFFFFFF0, 15);
      // gran: top is all ones
      prot_req("R4", 32'h0, 20'h0, 1, 1, 0, 1, 32'hFFFFFFFA, 0, 32'hFFFFFFFA, 5);
   endtask

   task automatic t_perm();
      prot_req("R5", 32'h1000, 20'hFF, 0, 0, 1, 1, 32'h10, 0, 32'h1010, 0);
      prot_req("R5", 32'h1000, 20'hFF, 0, 0, 0, 0, 32'h10, 1, 32'h1010, 0);
      prot_req("R5", 32'h1000, 20'hFF, 0, 0, 0, 0, 32'h10, 0, 32'h1010, 240);
   endtask

   task automatic t_v86();
      @(negedge clk);
      mode = 2'd1; selector = 16'h1234; offset = 32'h10; is_write = 1'b1;
      cs_override = 1'b1; exec_only = 1'b1; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      check("R6", "v86 addr", lin_addr, 32'h12350);
      check("R6", "v86 window", window, 255);
      check("R6", "v86 fault", fault, 0);
      exec_only = 1'b0;
   endtask

   task automatic t_flat();
      @(negedge clk);
      mode = 2'd0; offset = 32'hDEAD0000; is_write = 1'b1; cs_override = 1'b1;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      check("R7", "flat addr", lin_addr, 32'hDEAD0000);
      check("R7", "flat window", window, 255);
      check("R7", "flat cs write fault", fault, 1);
      @(negedge clk);
      is_write = 1'b0; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      check("R7", "flat cs read no fault", fault, 0);
   endtask

   task automatic t_timing();
      // after a request, done drops and results hold while inputs change
      @(negedge clk);
      mode = 2'd0; offset = 32'h5555; is_write = 1'b0; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      check("R8", "done pulse", done, 1);
      offset = 32'hAAAA; mode = 2'd1;
      @(negedge clk);
      check("R8", "done low", done, 0);
      check("R8", "addr held", lin_addr, 32'h5555);
      @(negedge clk);
      check("R8", "addr still held", lin_addr, 32'h5555);
   endtask

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      fails++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      t_expand_up();
      t_gran_wrap();
      t_expand_down();
      t_perm();
      t_v86();
      t_flat();
      t_timing();
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule